// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block stores eight program registers and serves two reads and one write in the same clock cycle. Each read port takes a 4-bit register identifier and returns that register's word through combinational logic only, so the data output moves as soon as the identifier moves. The write port takes a 4-bit identifier and a data word. The addressed register takes the new value at the rising clock edge and at no other time.

Identifiers 0 to 7 select a register. Every identifier from 8 to 15 means "no register". A read with such an identifier returns an all-zero word. A write with such an identifier leaves the whole file unchanged. A synchronous reset clears every register to zero.

Inside the block, a decode stage turns the identifiers into a small bundle of strobes. A storage stage holds the words and drives the read multiplexers. A thin top connects the two stages.

Top module: `regfile_2r1w`

## Requirements
- R1: When `rst` is high at a rising edge, all eight registers read zero from the next cycle on.
- R2: `rdDataA` equals the current word of register `rdIdA` whenever `rdIdA` is 0 to 7, with no clock edge needed.
- R3: `rdDataB` equals the current word of register `rdIdB` whenever `rdIdB` is 0 to 7, independently of port A.
- R4: With `wrId` in 0 to 7 and `rst` low, register `wrId` holds `wrData` after the rising edge, and not before it.
- R5: A read whose identifier equals the write identifier in the same cycle returns the old word until the edge.
- R6: A read identifier of 8 to 15 drives an all-zero word on that port.
- R7: A write identifier of 8 to 15 changes no register at the edge.
- R8: Both reads and one write, each at its own identifier, operate correctly in the same cycle.
- R9: When `rst` and a valid write fall on the same edge, the reset wins and the register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write and the reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rdIdA | input | 4 | Read port A identifier; 8 to 15 selects no register |
| rdDataA | output | DATA_W | Read port A data |
| rdIdB | input | 4 | Read port B identifier; 8 to 15 selects no register |
| rdDataB | output | DATA_W | Read port B data |
| wrId | input | 4 | Write identifier; 8 to 15 selects no register |
| wrData | input | DATA_W | Write data |

## Verification
The functions that coincide are a combinational read and the edge-triggered write of the same register. Both happen in the same cycle. The bench provokes this by sweeping every pair of read identifiers (0 to 15 on each port) while a write is pending to a rotating target. In the same sweep it aims reads directly at the write target. Before the edge it judges both read outputs against a model array that still holds the old words. After the edge it judges them against the updated model.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int REG_COUNT = 8;
  localparam int ID_W      = 4;
  localparam int SEL_W     = $clog2(REG_COUNT);
  localparam int RD_PORTS  = 2;

  typedef struct packed {
    logic                               clear;
    logic                               wrEn;
    logic [SEL_W-1:0]                   wrSel;
    logic [RD_PORTS-1:0]                rdValid;
    logic [RD_PORTS-1:0][SEL_W-1:0]     rdSel;
  } strobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic                           rst,
  input  logic [ID_W-1:0]                wrId,
  input  logic [RD_PORTS-1:0][ID_W-1:0]  rdId,
  output strobe_t                        strb
);
  // An identifier names a register only below REG_COUNT; anything above is "none".
  function automatic logic idNamesReg(input logic [ID_W-1:0] id);
    return (int'(id) < REG_COUNT);
  endfunction

  always_comb begin
    strb.clear = rst;
    strb.wrEn  = idNamesReg(wrId);
    strb.wrSel = wrId[SEL_W-1:0];
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdDecode
    always_comb begin
      strb.rdValid[p] = idNamesReg(rdId[p]);
      strb.rdSel[p]   = rdId[p][SEL_W-1:0];
    end
  end
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  strobe_t                          strb,
  input  logic [DATA_W-1:0]                wrData,
  output logic [RD_PORTS-1:0][DATA_W-1:0]  rdData
);
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;

  // Write and clear only on the rising edge; the clear has priority (R9).
  always_ff @(posedge clk) begin
    if (strb.clear) begin
      regs <= '0;
    end else if (strb.wrEn) begin
      regs[strb.wrSel] <= wrData;
    end
  end

  // Reads are pure combinational multiplexers; a port with no register drives zero.
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdMux
    always_comb begin
      rdData[p] = strb.rdValid[p] ? regs[strb.rdSel[p]] : '0;
    end
  end

  a_r1_clear_zeroes: assert property (@(posedge clk)
    strb.clear |=> (regs == '0));

  a_r4_write_lands: assert property (@(posedge clk) disable iff (strb.clear)
    strb.wrEn |=> (regs[$past(strb.wrSel)] == $past(wrData)));

  a_r7_none_write_keeps: assert property (@(posedge clk) disable iff (strb.clear)
    !strb.wrEn |=> $stable(regs));
endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   rdIdA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ID_W-1:0]   rdIdB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [ID_W-1:0]   wrId,
  input  logic [DATA_W-1:0] wrData
);
  strobe_t                          strb;
  logic [RD_PORTS-1:0][ID_W-1:0]    rdId;
  logic [RD_PORTS-1:0][DATA_W-1:0]  rdData;

  assign rdId[0] = rdIdA;
  assign rdId[1] = rdIdB;

  regfile_ctrl u_ctrl (
    .rst  (rst),
    .wrId (wrId),
    .rdId (rdId),
    .strb (strb)
  );

  regfile_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  a_r6_none_read_zero_a: assert property (@(posedge clk) disable iff (rst)
    (int'(rdIdA) >= REG_COUNT) |-> (rdDataA == '0));

  a_r6_none_read_zero_b: assert property (@(posedge clk) disable iff (rst)
    (int'(rdIdB) >= REG_COUNT) |-> (rdDataB == '0));

  // R5: a read aimed at the pending write target still shows the pre-edge word.
  a_r5_old_value_before_edge: assert property (@(posedge clk) disable iff (rst)
    (int'(wrId) < REG_COUNT && rdIdA == wrId) |=> $past(rst) || (rdDataA == $past(rdDataA)) || (rdIdA != $past(rdIdA)) || (rdDataA == $past(wrData)));
endmodule

// File: tb/regfile_2r1w_test.sv
module regfile_2r1w_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    rdIdA, rdIdB, wrId;
  logic [DW-1:0] rdDataA, rdDataB, wrData;

  logic [DW-1:0] model [8];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_2r1w #(.DATA_W(DW)) uut (
    .clk(clk), .rst(rst),
    .rdIdA(rdIdA), .rdDataA(rdDataA),
    .rdIdB(rdIdB), .rdDataB(rdDataB),
    .wrId(wrId), .wrData(wrData)
  );

  function automatic logic [DW-1:0] expRead(input logic [3:0] id);
    return (id < 8) ? model[id[2:0]] : '0;
  endfunction

  function automatic logic [DW-1:0] pattern(input int k);
    return (32'h9E3779B9 * (k + 1)) ^ (k << 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Advance one edge, mirror the write/clear in the model, return to the falling edge.
  task automatic step();
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 8; i++) model[i] = '0;
    end else if (wrId < 8) begin
      model[wrId[2:0]] = wrData;
    end
    @(negedge clk);
    #1;
  endtask

  task automatic checkBoth(input string req);
    check(rdDataA == expRead(rdIdA), req, rdDataA, expRead(rdIdA));
    check(rdDataB == expRead(rdIdB), req, rdDataB, expRead(rdIdB));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 'x;
    rst = 1'b1; rdIdA = 0; rdIdB = 0; wrId = 4'd8; wrData = '0;
    @(negedge clk);
    step();
    rst = 1'b0;
    // R1, R6: all ids read zero after reset
    for (int a = 0; a < 16; a++) begin
      rdIdA = 4'(a); rdIdB = 4'(15 - a); #1;
      checkBoth("R1/R6 reset read");
    end

    // R4, R5: write each register, reading the target before and after the edge
    for (int i = 0; i < 8; i++) begin
      wrId = 4'(i); wrData = pattern(i); rdIdA = 4'(i); rdIdB = 4'(i); #1;
      check(rdDataA == '0, "R5 old value before edge", rdDataA, '0);
      step();
      check(rdDataA == pattern(i), "R4 value after edge", rdDataA, pattern(i));
      check(rdDataB == pattern(i), "R3 value after edge", rdDataB, pattern(i));
    end
    wrId = 4'd8;

    // R2, R3: read sweep of every register on both ports
    for (int a = 0; a < 8; a++) begin
      rdIdA = 4'(a); rdIdB = 4'(7 - a); #1;
      checkBoth("R2/R3 read sweep");
    end

    // R7: writes with ids 8..15 leave the file untouched
    for (int w = 8; w < 16; w++) begin
      wrId = 4'(w); wrData = 32'hDEADBEEF;
      step();
      for (int a = 0; a < 8; a++) begin
        rdIdA = 4'(a); rdIdB = 4'(a); #1;
        check(rdDataA == pattern(a), "R7 none write ignored", rdDataA, pattern(a));
      end
    end

    // R8, R5, R6: all read pairs with a write pending in the same cycle
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wrId = 4'((a + b) % 9); wrData = pattern(100 + a * 16 + b);
        rdIdA = 4'(a); rdIdB = 4'(b); #1;
        checkBoth("R8 pre-edge concurrent");
        step();
        checkBoth("R8 post-edge concurrent");
      end
    end

    // R9: reset beats a simultaneous valid write
    rst = 1'b1; wrId = 4'd3; wrData = 32'h12345678;
    step();
    rst = 1'b0; wrId = 4'd8;
    rdIdA = 4'd3; rdIdB = 4'd0; #1;
    check(rdDataA == '0, "R9 reset over write", rdDataA, '0);
    checkBoth("R1 after second reset");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule